// File: doc/BRIEF.md
# Parity-Checked Status Calendar

This block stores the port calendar that a packet interface's transmit side uses to tell which port each slot on the incoming flow-control status channel belongs to. There are 128 four-bit port entries, packed four to a word across 32 words. Each word also carries one odd-parity bit. While the interface is disabled, software fills the table one word at a time and can read it back. Software also supplies the parity bit, so a fault can be injected deliberately.

Once the interface and the status channel are both enabled and a nonzero calendar length is set, a walker starts. It waits for a framing slot, steps through entries 0 to LEN-1, repeats that pass M times, and then waits for the next framing slot. For every status slot it reads the table entry, checks the parity of the word that holds it, and reports the port number together with the received two-bit status.

A parity failure marks the bank where it occurred (words 0-15 or words 16-31) and stops the walker. The walker stays stopped until the interface enable is dropped. A per-port ignore mask replaces the received status with a full-credit grant indication for the masked ports.

Top module: `portCalendar`

## Requirements
- R1: Word k holds entry 4k+j in bits [4j+3:4j], for j = 0 to 3. Bit 16 is odd parity, so the XOR of bits [16:0] is 1. After reset every word reads 17'h10000: all entries are port 0 and the parity is valid.
- R2: With `ifEn` low, a write stores `swWdata` at word `swAddr`. A read returns the stored word on `swRdata` in the cycle after `swRd`, and `swRdata` is zero in every other cycle.
- R3: With `ifEn` high, software writes are dropped and software reads return zero.
- R4: The calendar runs (`calRunning` high) only when `ifEn` and `stEn` are both high, `calLen` is nonzero and no parity error is flagged. Slots that arrive while it is stopped produce no output.
- R5: On starting, and after each complete set of passes, the walker waits for a slot whose status is 2'b11 (framing). Slots with any other status are ignored in that state.
- R6: After framing, the walker assigns successive slots to entries 0 to `calLen`-1 in order and repeats the pass `calRep` times; a value of 0 counts as 1. It then returns to waiting for framing.
- R7: Each slot assigned to an entry gives `slotValid` one cycle after `slotStrobe`, together with that entry's port on `slotPort` and the received status on `slotStat`.
- R8: If the word read for a slot fails parity, no `slotValid` is produced. Bit 0 of `parErr` is set for words 0-15 and bit 1 for words 16-31, and the calendar stops.
- R9: `parErr` bits remain set while `ifEn` stays high. One clock edge with `ifEn` low clears them, and the walker restarts from the framing wait.
- R10: When `ignoreMask[p]` is set, a slot for port p reports `slotStat` = 2'b00 (full-credit grant) and `slotOverride` = 1. Otherwise `slotOverride` is 0 and the received status passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifEn | input | 1 | Interface enable; low allows table access and clears errors |
| stEn | input | 1 | Status channel enable |
| calLen | input | 7 | Entries per calendar pass |
| calRep | input | 8 | Passes per framing period (0 treated as 1) |
| ignoreMask | input | 16 | Per-port status override |
| swRd | input | 1 | Software word read request |
| swWr | input | 1 | Software word write request |
| swAddr | input | 5 | Software word address |
| swWdata | input | 17 | Software write word including parity bit |
| swRdata | output | 17 | Software read word, one cycle after request |
| slotStrobe | input | 1 | Status slot present |
| slotStatus | input | 2 | Received status of the slot |
| slotValid | output | 1 | Slot assigned to a port |
| slotPort | output | 4 | Port of the assigned slot |
| slotStat | output | 2 | Reported status (00 when overridden) |
| slotOverride | output | 1 | Port was in the ignore mask |
| parErr | output | 2 | Sticky per-bank parity error |
| calRunning | output | 1 | Calendar walker active |

## Verification
Every result of the block is registered exactly once. The slot outputs and the parity flags appear one cycle after the strobe, a software read answers one cycle after the request, and a low `ifEn` clears the flags at the next edge. `calRunning` is combinational from those flags and the control inputs. The bench applies every input half a cycle before an edge. For each stimulus it lets exactly one edge pass and samples on the following falling edge, so every check looks at the single cycle in which the result is due. Walk sweeps over several lengths and repeat counts compute the expected port from an arithmetic fill pattern. Parity faults are injected in each bank at a known entry, so the slot at which the valid output must vanish is known in advance.

// File: rtl/portCalPkg.sv
package portCalPkg;
  localparam int STAT_W = 2;
  localparam logic [STAT_W-1:0] FRAME_CODE = 2'b11;
  localparam logic [STAT_W-1:0] GRANT_CODE = 2'b00;

  typedef enum logic {W_FRAME, W_WALK} walkSt_t;

  typedef struct packed {
    logic              rdFire;
    logic [STAT_W-1:0] slotStat;
  } calCtl_t;
endpackage

// File: rtl/calWalker.sv
module calWalker
  import portCalPkg::*;
#(
  parameter int IDX_W = 7,
  parameter int REP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              slotStrobe,
  input  logic [STAT_W-1:0] slotStatus,
  input  logic [IDX_W-1:0]  calLen,
  input  logic [REP_W-1:0]  calRep,
  output calCtl_t           ctl,
  output logic [IDX_W-1:0]  entryIdx
);
  walkSt_t          st;
  logic [IDX_W-1:0] idx;
  logic [REP_W-1:0] rep;
  logic [REP_W-1:0] repEff;
  logic             lastEnt;
  logic             lastRep;

  assign repEff  = (calRep == '0) ? REP_W'(1) : calRep;
  assign lastEnt = (idx == calLen - 1'b1);
  assign lastRep = (rep == repEff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !running) begin
      st  <= W_FRAME;
      idx <= '0;
      rep <= '0;
    end else if (slotStrobe) begin
      case (st)
        W_FRAME: begin
          if (slotStatus == FRAME_CODE) begin
            st  <= W_WALK;
            idx <= '0;
            rep <= '0;
          end
        end
        default: begin
          if (lastEnt) begin
            idx <= '0;
            if (lastRep) begin
              st  <= W_FRAME;
              rep <= '0;
            end else begin
              rep <= rep + 1'b1;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.rdFire   = running && slotStrobe && (st == W_WALK);
    ctl.slotStat = slotStatus;
    entryIdx     = idx;
  end
endmodule

// File: rtl/calStore.sv
module calStore
  import portCalPkg::*;
#(
  parameter int NUM_WORDS    = 32,
  parameter int ENT_PER_WORD = 4,
  parameter int ENT_W        = 4,
  parameter int NUM_BANKS    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ifEn,
  input  calCtl_t                              ctl,
  input  logic [$clog2(NUM_WORDS*ENT_PER_WORD)-1:0] entryIdx,
  input  logic [(1<<ENT_W)-1:0]                ignoreMask,
  input  logic                                 swRd,
  input  logic                                 swWr,
  input  logic [$clog2(NUM_WORDS)-1:0]         swAddr,
  input  logic [ENT_PER_WORD*ENT_W:0]          swWdata,
  output logic [ENT_PER_WORD*ENT_W:0]          swRdata,
  output logic                                 slotValid,
  output logic [ENT_W-1:0]                     slotPort,
  output logic [STAT_W-1:0]                    slotStat,
  output logic                                 slotOverride,
  output logic [NUM_BANKS-1:0]                 parErr
);
  localparam int DATA_W = ENT_PER_WORD * ENT_W;
  localparam int WORD_W = DATA_W + 1;
  localparam int ADDR_W = $clog2(NUM_WORDS);
  localparam int SUB_W  = $clog2(ENT_PER_WORD);
  localparam int IDX_W  = ADDR_W + SUB_W;
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [WORD_W-1:0] RESET_WORD = {1'b1, {DATA_W{1'b0}}};

  logic [WORD_W-1:0] mem [NUM_WORDS];
  logic [ADDR_W-1:0] wordSel;
  logic [SUB_W-1:0]  subSel;
  logic [WORD_W-1:0] rdWord;
  logic              parOk;
  logic [ENT_W-1:0]  entry;
  logic [BANK_W-1:0] bankSel;
  logic              swAllowed;

  assign wordSel   = entryIdx[IDX_W-1:SUB_W];
  assign subSel    = entryIdx[SUB_W-1:0];
  assign rdWord    = mem[wordSel];
  assign parOk     = ^rdWord;
  assign entry     = rdWord[subSel*ENT_W +: ENT_W];
  assign swAllowed = !ifEn;

  generate
    if (NUM_BANKS > 1) begin : g_multiBank
      assign bankSel = wordSel[ADDR_W-1 -: BANK_W];
    end else begin : g_oneBank
      assign bankSel = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= RESET_WORD;
      swRdata <= '0;
    end else begin
      if (swWr && swAllowed) mem[swAddr] <= swWdata;
      swRdata <= (swRd && swAllowed) ? mem[swAddr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotValid    <= 1'b0;
      slotPort     <= '0;
      slotStat     <= '0;
      slotOverride <= 1'b0;
    end else begin
      slotValid    <= ctl.rdFire && parOk;
      slotPort     <= entry;
      slotOverride <= ignoreMask[entry];
      slotStat     <= ignoreMask[entry] ? GRANT_CODE : ctl.slotStat;
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankErr
      always_ff @(posedge clk) begin
        if (!rst_n || !ifEn) begin
          parErr[b] <= 1'b0;
        end else if (ctl.rdFire && !parOk && (bankSel == BANK_W'(b))) begin
          parErr[b] <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/portCalendar.sv
module portCalendar
  import portCalPkg::*;
#(
  parameter int NUM_WORDS    = 32,
  parameter int ENT_PER_WORD = 4,
  parameter int ENT_W        = 4,
  parameter int NUM_BANKS    = 2,
  parameter int REP_W        = 8,
  localparam int IDX_W       = $clog2(NUM_WORDS*ENT_PER_WORD),
  localparam int ADDR_W      = $clog2(NUM_WORDS),
  localparam int WORD_W      = ENT_PER_WORD*ENT_W + 1,
  localparam int NUM_PORTS   = 1 << ENT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ifEn,
  input  logic                 stEn,
  input  logic [IDX_W-1:0]     calLen,
  input  logic [REP_W-1:0]     calRep,
  input  logic [NUM_PORTS-1:0] ignoreMask,
  input  logic                 swRd,
  input  logic                 swWr,
  input  logic [ADDR_W-1:0]    swAddr,
  input  logic [WORD_W-1:0]    swWdata,
  output logic [WORD_W-1:0]    swRdata,
  input  logic                 slotStrobe,
  input  logic [STAT_W-1:0]    slotStatus,
  output logic                 slotValid,
  output logic [ENT_W-1:0]     slotPort,
  output logic [STAT_W-1:0]    slotStat,
  output logic                 slotOverride,
  output logic [NUM_BANKS-1:0] parErr,
  output logic                 calRunning
);
  calCtl_t          ctl;
  logic [IDX_W-1:0] entryIdx;

  assign calRunning = ifEn && stEn && (calLen != '0) && (parErr == '0);

  calWalker #(.IDX_W(IDX_W), .REP_W(REP_W)) walker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (calRunning),
    .slotStrobe (slotStrobe),
    .slotStatus (slotStatus),
    .calLen     (calLen),
    .calRep     (calRep),
    .ctl        (ctl),
    .entryIdx   (entryIdx)
  );

  calStore #(
    .NUM_WORDS    (NUM_WORDS),
    .ENT_PER_WORD (ENT_PER_WORD),
    .ENT_W        (ENT_W),
    .NUM_BANKS    (NUM_BANKS)
  ) store_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ifEn         (ifEn),
    .ctl          (ctl),
    .entryIdx     (entryIdx),
    .ignoreMask   (ignoreMask),
    .swRd         (swRd),
    .swWr         (swWr),
    .swAddr       (swAddr),
    .swWdata      (swWdata),
    .swRdata      (swRdata),
    .slotValid    (slotValid),
    .slotPort     (slotPort),
    .slotStat     (slotStat),
    .slotOverride (slotOverride),
    .parErr       (parErr)
  );
endmodule

// File: rtl/portCalendar_chk.sv
module portCalendar_chk #(
  parameter int WORD_W    = 17,
  parameter int NUM_BANKS = 2,
  parameter int STAT_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ifEn,
  input logic                 stEn,
  input logic                 slotStrobe,
  input logic                 slotValid,
  input logic [STAT_W-1:0]    slotStat,
  input logic                 slotOverride,
  input logic [WORD_W-1:0]    swRdata,
  input logic [NUM_BANKS-1:0] parErr
);
  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rst_n) pastOk <= 1'b0;
    else        pastOk <= 1'b1;
  end

  // R7: a slot result is always the answer to a strobe one cycle earlier
  p_valid_follows_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && slotValid) |-> $past(slotStrobe));

  // R4: a slot result implies both enables were high at the strobe
  p_valid_needs_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && slotValid) |-> $past(ifEn && stEn));

  // R3: no read data leaves the block while the interface is enabled
  p_blocked_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ifEn |=> (swRdata == '0));

  // R8: a reported slot never coincides with a new parity error
  p_no_valid_on_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && slotValid) |-> $stable(parErr));

  // R9: error flags hold while enabled and clear once disabled
  p_error_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((parErr != '0) && ifEn) |=> ((parErr & $past(parErr)) == $past(parErr)));
  p_error_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ifEn |=> (parErr == '0));

  // R10: an overridden slot reports the grant code
  p_override_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slotValid && slotOverride) |-> (slotStat == '0));
endmodule

bind portCalendar portCalendar_chk #(
  .WORD_W    (WORD_W),
  .NUM_BANKS (NUM_BANKS),
  .STAT_W    (portCalPkg::STAT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ifEn         (ifEn),
  .stEn         (stEn),
  .slotStrobe   (slotStrobe),
  .slotValid    (slotValid),
  .slotStat     (slotStat),
  .slotOverride (slotOverride),
  .swRdata      (swRdata),
  .parErr       (parErr)
);

// File: tb/portCalendar_tb_top.sv
module portCalendar_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ifEn = 1'b0, stEn = 1'b0;
  logic [6:0]  calLen = '0;
  logic [7:0]  calRep = '0;
  logic [15:0] ignoreMask = '0;
  logic        swRd = 1'b0, swWr = 1'b0;
  logic [4:0]  swAddr = '0;
  logic [16:0] swWdata = '0;
  logic [16:0] swRdata;
  logic        slotStrobe = 1'b0;
  logic [1:0]  slotStatus = '0;
  logic        slotValid;
  logic [3:0]  slotPort;
  logic [1:0]  slotStat;
  logic        slotOverride;
  logic [1:0]  parErr;
  logic        calRunning;

  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;

  portCalendar dut_i (
    .clk(clk), .rst_n(rst_n), .ifEn(ifEn), .stEn(stEn), .calLen(calLen),
    .calRep(calRep), .ignoreMask(ignoreMask), .swRd(swRd), .swWr(swWr),
    .swAddr(swAddr), .swWdata(swWdata), .swRdata(swRdata),
    .slotStrobe(slotStrobe), .slotStatus(slotStatus), .slotValid(slotValid),
    .slotPort(slotPort), .slotStat(slotStat), .slotOverride(slotOverride),
    .parErr(parErr), .calRunning(calRunning)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int portOf(input int e);
    return (e * 7 + e / 16) % 16;
  endfunction

  function automatic logic [16:0] wordOf(input int k);
    logic [15:0] d;
    for (int j = 0; j < 4; j++) d[4*j +: 4] = 4'(portOf(4*k + j));
    return {~^d, d};
  endfunction

  task automatic swWrite(input int a, input logic [16:0] d);
    @(negedge clk); swWr = 1'b1; swAddr = 5'(a); swWdata = d;
    @(negedge clk); swWr = 1'b0;
  endtask

  task automatic swRead(input int a, output logic [16:0] d);
    @(negedge clk); swRd = 1'b1; swAddr = 5'(a);
    @(negedge clk); swRd = 1'b0; d = swRdata;
  endtask

  task automatic doSlot(input logic [1:0] st);
    @(negedge clk); slotStrobe = 1'b1; slotStatus = st;
    @(negedge clk); slotStrobe = 1'b0;
  endtask

  task automatic configure(input int len, input int rep, input logic [15:0] mask);
    @(negedge clk); ifEn = 1'b0;
    @(negedge clk); calLen = 7'(len); calRep = 8'(rep); ignoreMask = mask;
    ifEn = 1'b1; stEn = 1'b1;
  endtask

  task automatic runWalk(input int len, input int rep, input logic [15:0] mask);
    int reps;
    configure(len, rep, mask);
    reps = (rep == 0) ? 1 : rep;
    doSlot(2'b01); chk("R5 non-framing slot ignored", slotValid, 0);
    doSlot(2'b11); chk("R5 framing slot gives no output", slotValid, 0);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < len; i++) begin
        logic [1:0] st;
        int p;
        st = 2'((i + r) % 3);
        p = portOf(i);
        doSlot(st);
        chk("R7 slot valid", slotValid, 1);
        chk("R6 entry order port", slotPort, p);
        chk("R10 reported status", slotStat, mask[p] ? 0 : int'(st));
        chk("R10 override flag", slotOverride, int'(mask[p]));
      end
    end
    doSlot(2'b01); chk("R6 waits for framing after M passes", slotValid, 0);
    doSlot(2'b11);
    doSlot(2'b10);
    chk("R6 restart valid", slotValid, 1);
    chk("R6 restart at entry 0", slotPort, portOf(0));
  endtask

  initial begin
    #(200000 * 20);
    errs++; vecs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [16:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset running", calRunning, 0);
    chk("R8 reset parErr", parErr, 0);
    chk("R7 reset slotValid", slotValid, 0);
    chk("R2 reset swRdata", swRdata, 0);
    swRead(5, rd); chk("R1 reset word content", rd, 17'h10000);

    for (int k = 0; k < 32; k++) swWrite(k, wordOf(k));
    for (int k = 0; k < 32; k++) begin
      swRead(k, rd);
      chk("R2 word readback", rd, wordOf(k));
      chk("R1 odd parity", ^rd, 1);
      for (int j = 0; j < 4; j++)
        chk("R1 entry field position", (rd >> (4*j)) & 17'hF, portOf(4*k + j));
    end
    @(negedge clk); chk("R2 swRdata idle zero", swRdata, 0);

    // R3: blocked access while enabled
    @(negedge clk); ifEn = 1'b1;
    swRead(3, rd); chk("R3 read while enabled", rd, 0);
    swWrite(3, 17'h0);
    @(negedge clk); ifEn = 1'b0;
    swRead(3, rd); chk("R3 write while enabled dropped", rd, wordOf(3));

    // R4: run conditions
    configure(0, 1, 16'h0);
    @(negedge clk); chk("R4 zero length stops", calRunning, 0);
    doSlot(2'b11); doSlot(2'b01); chk("R4 no slot with zero length", slotValid, 0);
    @(negedge clk); calLen = 7'd5; stEn = 1'b0;
    @(negedge clk); chk("R4 status disabled stops", calRunning, 0);
    doSlot(2'b11); doSlot(2'b01); chk("R4 no slot with status disabled", slotValid, 0);
    @(negedge clk); stEn = 1'b1;
    @(negedge clk); chk("R4 running", calRunning, 1);

    runWalk(5, 3, 16'h0);
    runWalk(1, 0, 16'h0);
    runWalk(127, 1, 16'h0);
    runWalk(4, 2, 16'(1 << portOf(2)));
    runWalk(7, 1, 16'hFFFF);

    // R8 bank 0: corrupt word 2 (entries 8..11)
    @(negedge clk); ifEn = 1'b0;
    swWrite(2, wordOf(2) ^ 17'h10000);
    configure(12, 1, 16'h0);
    doSlot(2'b11);
    for (int i = 0; i < 8; i++) begin
      doSlot(2'b01);
      chk("R8 slots before bad word", slotValid, 1);
    end
    doSlot(2'b01);
    chk("R8 bad word gives no valid", slotValid, 0);
    chk("R8 bank0 flag", parErr, 1);
    chk("R8 calendar stopped", calRunning, 0);
    doSlot(2'b11); doSlot(2'b01);
    chk("R9 stays down while enabled", slotValid, 0);
    chk("R9 flag sticky", parErr, 1);
    @(negedge clk); ifEn = 1'b0;
    @(negedge clk); chk("R9 flag cleared by disable", parErr, 0);
    swWrite(2, wordOf(2));

    // R8 bank 1: corrupt word 20 (entries 80..83)
    swWrite(20, wordOf(20) ^ 17'h00001);
    configure(82, 1, 16'h0);
    doSlot(2'b11);
    for (int i = 0; i < 80; i++) doSlot(2'b10);
    chk("R8 last good slot valid", slotValid, 1);
    chk("R8 last good port", slotPort, portOf(79));
    doSlot(2'b10);
    chk("R8 bank1 bad word no valid", slotValid, 0);
    chk("R8 bank1 flag", parErr, 2);
    @(negedge clk); ifEn = 1'b0;
    swWrite(20, wordOf(20));
    @(negedge clk); ifEn = 1'b1;
    @(negedge clk); chk("R9 running again after toggle", calRunning, 1);
    doSlot(2'b01); chk("R9 restart waits for framing", slotValid, 0);
    doSlot(2'b11); doSlot(2'b01);
    chk("R9 restart first entry", slotPort, portOf(0));
    chk("R9 restart valid", slotValid, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule